// File: doc/BRIEF.md
# Battery Pack Protection Switch Controller

This block decides, once per clock, whether the low-side charge switch and the low-side discharge switch of a battery pack should be driven on. Each fault flag arriving from the detectors passes through a per-fault mask that says whether the controller may act on it alone. A masked-in fault removes the drive of the switch it belongs to. Host commands can block either switch outright. They can also force a switch on, but only while a configuration bit allows forcing.

In a series switch arrangement the controller can protect a body diode. When one switch is held off by a fault and the other is on, a large current through the off switch's body diode turns the off switch back on. The current is a signed sample, and the controller compares its magnitude with a programmable threshold. The controller also enables the discharge overcurrent detectors only while the discharge switch is on. Each time the charge switch turns off, it raises an active pull-low strobe for a fixed number of cycles and then releases the pin.

Top module: `fet_guard`

## Requirements
- R1: Fault vector bit positions are: 0 undervoltage, 1 overvoltage, 2 discharge over-temperature, 3 discharge under-temperature, 4 charge over-temperature, 5 charge under-temperature, 6 discharge overcurrent tier A, 7 discharge overcurrent tier B, 8 charge overcurrent, 9 short circuit, 10 discharge-side diagnostic, 11 charge-side diagnostic. Any of bits 0, 2, 3, 6, 7, 9, 10 set together with its `auto_en_i` bit drives `dsg_on_o` low one cycle later, unless a permitted force or body diode turn-on applies.
- R2: Any of bits 1, 4, 5, 8, 9, 11 set together with its `auto_en_i` bit drives `chg_on_o` low one cycle later, unless a permitted force or body diode turn-on applies.
- R3: A fault whose `auto_en_i` bit is 0 has no effect on either switch. With no routed fault and no block, both switches are on one cycle later.
- R4: `blk_dsg_i` / `blk_chg_i` turn their switch off one cycle later. This overrides faults, force and body diode turn-on.
- R5: `frc_dsg_i` / `frc_chg_i` turn their unblocked switch on despite routed faults only while `frc_allow_i` is 1. With `frc_allow_i` at 0 they have no effect.
- R6: With `series_i`=1 and `bd_en_i`=1, a fault-inhibited, unblocked discharge switch turns on when the charge switch is requested on and `cur_i` (two's complement, positive = charging) is positive with magnitude strictly greater than `bd_thr_i`.
- R7: Under the same enables, a fault-inhibited, unblocked charge switch turns on when the discharge switch is requested on and `cur_i` is negative with magnitude strictly greater than `bd_thr_i`. This includes the most negative sample.
- R8: No body diode turn-on occurs in parallel mode (`series_i`=0), with `bd_en_i`=0, or with magnitude equal to or below the threshold.
- R9: `ocd_en_o` equals `dsg_on_o` in every cycle. The charge switch state has no influence on it.
- R10: On the clock edge where `chg_on_o` falls, `chg_pull_lo_o` rises. It stays high for exactly PULL_CYC cycles and then falls.
- R11: If the charge switch turns back on during the strobe, the strobe drops on that same edge. `chg_pull_lo_o` is never high while `chg_on_o` is high.
- R12: Asserting `rst_n` low clears all four outputs at once, without waiting for a clock edge. Release passes through a two-stage synchronizer, and after that the outputs follow their inputs with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_i | input | 12 | Fault flags, positions as in R1 |
| auto_en_i | input | 12 | Per-fault autonomous-control enables |
| blk_chg_i | input | 1 | Host block of the charge switch |
| blk_dsg_i | input | 1 | Host block of the discharge switch |
| frc_chg_i | input | 1 | Host force-on of the charge switch |
| frc_dsg_i | input | 1 | Host force-on of the discharge switch |
| frc_allow_i | input | 1 | Configuration permission for force-on |
| series_i | input | 1 | 1 = series switches, 0 = parallel |
| bd_en_i | input | 1 | Body diode protection enable |
| cur_i | input | CW | Signed current sample, positive = charging |
| bd_thr_i | input | CW | Unsigned body diode current threshold |
| chg_on_o | output | 1 | Charge switch drive request |
| dsg_on_o | output | 1 | Discharge switch drive request |
| ocd_en_o | output | 1 | Discharge overcurrent detector enable |
| chg_pull_lo_o | output | 1 | Active pull-low strobe after charge turn-off |

## Verification
The properties assume that every input is synchronous to the clock and holds steady between rising edges. They also assume that the fault routing checks only apply when body diode protection cannot act, because it is disabled or the mode is parallel. The stimulus changes inputs only on falling edges. It enables body diode protection only in the vectors written for R6 to R8, so the routing properties stay in force for all other vectors.

// File: rtl/fetg_pkg.sv
package fetg_pkg;
  localparam int NFLT = 12;

  localparam int FB_UNDERV   = 0;
  localparam int FB_OVERV    = 1;
  localparam int FB_HOT_DSG  = 2;
  localparam int FB_COLD_DSG = 3;
  localparam int FB_HOT_CHG  = 4;
  localparam int FB_COLD_CHG = 5;
  localparam int FB_OCD_A    = 6;
  localparam int FB_OCD_B    = 7;
  localparam int FB_OC_CHG   = 8;
  localparam int FB_SHORT    = 9;
  localparam int FB_DIAG_D   = 10;
  localparam int FB_DIAG_C   = 11;

  localparam logic [NFLT-1:0] DSG_ROUTE =
      NFLT'((1 << FB_UNDERV) | (1 << FB_HOT_DSG) | (1 << FB_COLD_DSG) |
            (1 << FB_OCD_A) | (1 << FB_OCD_B) | (1 << FB_SHORT) | (1 << FB_DIAG_D));
  localparam logic [NFLT-1:0] CHG_ROUTE =
      NFLT'((1 << FB_OVERV) | (1 << FB_HOT_CHG) | (1 << FB_COLD_CHG) |
            (1 << FB_OC_CHG) | (1 << FB_SHORT) | (1 << FB_DIAG_C));
endpackage

// File: rtl/fetg_route.sv
module fetg_route #(
  parameter int            NF    = 12,
  parameter logic [NF-1:0] ROUTE = '0
) (
  input  logic [NF-1:0] flt_i,
  input  logic [NF-1:0] auto_i,
  input  logic          blk_i,
  input  logic          frc_i,
  input  logic          frc_ok_i,
  output logic          inh_o,
  output logic          req_o
);
  // A fault only counts when it belongs to this switch and may act alone.
  always_comb begin
    inh_o = |(flt_i & auto_i & ROUTE);
    req_o = !blk_i && (!inh_o || (frc_i && frc_ok_i));
  end
endmodule

// File: rtl/fetg_bodydiode.sv
module fetg_bodydiode #(
  parameter int CW = 16
) (
  input  logic          series_i,
  input  logic          bd_en_i,
  input  logic [CW-1:0] cur_i,
  input  logic [CW-1:0] thr_i,
  input  logic          chg_req_i,
  input  logic          dsg_req_i,
  input  logic          blk_chg_i,
  input  logic          blk_dsg_i,
  output logic          bd_chg_o,
  output logic          bd_dsg_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] mag;
  logic          neg, over, armed;

  // Magnitude in CW unsigned bits also covers the most negative sample.
  always_comb begin
    neg   = cur_i[CW-1];
    mag   = neg ? (~cur_i + ONE) : cur_i;
    over  = mag > thr_i;
    armed = series_i && bd_en_i && over;
    // Decided on the normal requests, so the override cannot undo itself.
    bd_dsg_o = armed && !neg && chg_req_i && !dsg_req_i && !blk_dsg_i;
    bd_chg_o = armed &&  neg && dsg_req_i && !chg_req_i && !blk_chg_i;
  end
endmodule

// File: rtl/fetg_pulltimer.sv
module fetg_pulltimer #(
  parameter int PULL_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chg_q_i,
  input  logic chg_d_i,
  output logic pull_o
);
  localparam int              CNTW = $clog2(PULL_CYC + 1);
  localparam logic [CNTW-1:0] LOAD = CNTW'(PULL_CYC);

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (chg_d_i) begin
      if (cnt_q != '0) begin
        cnt_d  = '0;
        cnt_en = 1'b1;
      end
    end else if (chg_q_i) begin
      cnt_d  = LOAD;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - CNTW'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pull_o = (cnt_q != '0);
endmodule

// File: rtl/fet_guard.sv
module fet_guard
  import fetg_pkg::*;
#(
  parameter int CW       = 16,
  parameter int PULL_CYC = 5000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [11:0]   flt_i,
  input  logic [11:0]   auto_en_i,
  input  logic          blk_chg_i,
  input  logic          blk_dsg_i,
  input  logic          frc_chg_i,
  input  logic          frc_dsg_i,
  input  logic          frc_allow_i,
  input  logic          series_i,
  input  logic          bd_en_i,
  input  logic [CW-1:0] cur_i,
  input  logic [CW-1:0] bd_thr_i,
  output logic          chg_on_o,
  output logic          dsg_on_o,
  output logic          ocd_en_o,
  output logic          chg_pull_lo_o
);
  logic [1:0] rst_sync;
  logic       rst_sync_n;
  logic       dsg_inh, chg_inh, dsg_req, chg_req, bd_dsg, bd_chg;
  logic       dsg_d, chg_d, dsg_q, chg_q, ocd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  fetg_route #(.NF(NFLT), .ROUTE(DSG_ROUTE)) u_route_dsg (
    .flt_i(flt_i), .auto_i(auto_en_i), .blk_i(blk_dsg_i), .frc_i(frc_dsg_i),
    .frc_ok_i(frc_allow_i), .inh_o(dsg_inh), .req_o(dsg_req));

  fetg_route #(.NF(NFLT), .ROUTE(CHG_ROUTE)) u_route_chg (
    .flt_i(flt_i), .auto_i(auto_en_i), .blk_i(blk_chg_i), .frc_i(frc_chg_i),
    .frc_ok_i(frc_allow_i), .inh_o(chg_inh), .req_o(chg_req));

  fetg_bodydiode #(.CW(CW)) u_bd (
    .series_i(series_i), .bd_en_i(bd_en_i), .cur_i(cur_i), .thr_i(bd_thr_i),
    .chg_req_i(chg_req), .dsg_req_i(dsg_req), .blk_chg_i(blk_chg_i),
    .blk_dsg_i(blk_dsg_i), .bd_chg_o(bd_chg), .bd_dsg_o(bd_dsg));

  always_comb begin
    dsg_d = dsg_req || bd_dsg;
    chg_d = chg_req || bd_chg;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dsg_q <= 1'b0;
      chg_q <= 1'b0;
      ocd_q <= 1'b0;
    end else begin
      dsg_q <= dsg_d;
      chg_q <= chg_d;
      ocd_q <= dsg_d;
    end
  end

  fetg_pulltimer #(.PULL_CYC(PULL_CYC)) u_pull (
    .clk(clk), .rst_n(rst_sync_n), .chg_q_i(chg_q), .chg_d_i(chg_d),
    .pull_o(chg_pull_lo_o));

  assign chg_on_o = chg_q;
  assign dsg_on_o = dsg_q;
  assign ocd_en_o = ocd_q;
endmodule

// File: rtl/fet_guard_chk.sv
module fet_guard_chk
  import fetg_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [11:0]   flt_i,
  input logic [11:0]   auto_en_i,
  input logic          blk_chg_i,
  input logic          blk_dsg_i,
  input logic          frc_chg_i,
  input logic          frc_dsg_i,
  input logic          frc_allow_i,
  input logic          series_i,
  input logic          bd_en_i,
  input logic [CW-1:0] cur_i,
  input logic          chg_on_o,
  input logic          dsg_on_o,
  input logic          ocd_en_o,
  input logic          chg_pull_lo_o
);
  logic dsg_f, chg_f, no_bd;
  assign dsg_f = |(flt_i & auto_en_i & DSG_ROUTE);
  assign chg_f = |(flt_i & auto_en_i & CHG_ROUTE);
  assign no_bd = !bd_en_i || !series_i;

  p_dsg_route_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dsg_f && !(frc_dsg_i && frc_allow_i) && no_bd) |=> !dsg_on_o);
  p_chg_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_f && !(frc_chg_i && frc_allow_i) && no_bd) |=> !chg_on_o);
  p_unrouted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dsg_f && !blk_dsg_i) |=> dsg_on_o);
  p_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_dsg_i || blk_chg_i) |=> (!(dsg_on_o && $past(blk_dsg_i)) && !(chg_on_o && $past(blk_chg_i))));
  p_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_allow_i && frc_chg_i && !blk_chg_i) |=> chg_on_o);
  p_ocd_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ocd_en_o == dsg_on_o);
  p_pull_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chg_on_o) |-> chg_pull_lo_o);
  p_no_pull_while_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
    chg_on_o |-> !chg_pull_lo_o);
endmodule

bind fet_guard fet_guard_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .flt_i(flt_i), .auto_en_i(auto_en_i),
  .blk_chg_i(blk_chg_i), .blk_dsg_i(blk_dsg_i), .frc_chg_i(frc_chg_i),
  .frc_dsg_i(frc_dsg_i), .frc_allow_i(frc_allow_i), .series_i(series_i),
  .bd_en_i(bd_en_i), .cur_i(cur_i), .chg_on_o(chg_on_o), .dsg_on_o(dsg_on_o),
  .ocd_en_o(ocd_en_o), .chg_pull_lo_o(chg_pull_lo_o));

// File: tb/test_fet_guard.sv
module test_fet_guard;
  localparam int CW   = 12;
  localparam int PULL = 10;
  localparam logic [11:0] DM = 12'h6CD;  // discharge-side bits per R1
  localparam logic [11:0] CM = 12'hB32;  // charge-side bits per R2

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] flt = '0, aut = '0;
  logic bc = 0, bd = 0, fc = 0, fd = 0, al = 0, ser = 0, bde = 0;
  logic signed [CW-1:0] cur = '0;
  logic [CW-1:0] thr = CW'(100);
  logic chg_on, dsg_on, ocd_en, pull;

  int n_chk = 0, n_bad = 0;
  logic [2:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #10 clk = ~clk;

  fet_guard #(.CW(CW), .PULL_CYC(PULL)) i_fet_guard (
    .clk(clk), .rst_n(rst_n), .flt_i(flt), .auto_en_i(aut), .blk_chg_i(bc),
    .blk_dsg_i(bd), .frc_chg_i(fc), .frc_dsg_i(fd), .frc_allow_i(al),
    .series_i(ser), .bd_en_i(bde), .cur_i(cur), .bd_thr_i(thr),
    .chg_on_o(chg_on), .dsg_on_o(dsg_on), .ocd_en_o(ocd_en), .chg_pull_lo_o(pull));

  // Expected {chg, dsg, ocd} from the requirement text.
  function automatic logic [2:0] model();
    logic dfl, cfl, dn, cn, big, dsg_e, chg_e;
    int mag;
    dfl = |(flt & aut & DM);
    cfl = |(flt & aut & CM);
    dn = !bd && (!dfl || (fd && al));
    cn = !bc && (!cfl || (fc && al));
    mag = (cur < 0) ? -int'(cur) : int'(cur);
    big = ser && bde && (mag > int'(thr));
    dsg_e = dn || (big && cur > 0 && cn && !bd);
    chg_e = cn || (big && cur < 0 && dn && !bc);
    return {chg_e, dsg_e, dsg_e};
  endfunction

  task automatic step(input string tag);
    exp_q.push_back(model());
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic clear_in();
    flt = '0; aut = '1; bc = 0; bd = 0; fc = 0; fd = 0; al = 0;
    ser = 0; bde = 0; cur = '0;
  endtask

  // Scoreboard monitor: compares after each register update.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() != 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " chg/dsg/ocd"}, {chg_on, dsg_on, ocd_en}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int len;
    clear_in();
    repeat (3) @(negedge clk);
    chk("R12 reset outputs", {chg_on, dsg_on, ocd_en, pull}, 4'b0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 after release", {chg_on, dsg_on, ocd_en}, 3'b111);

    // R1 R2: each fault alone with its enable
    for (int i = 0; i < 12; i++) begin
      clear_in(); flt[i] = 1'b1;
      step($sformatf("R1 R2 fault bit %0d", i));
    end
    // R3: faults present but not enabled
    clear_in(); flt = '1; aut = '0; step("R3 all faults masked");
    clear_in(); flt = '1; aut = ~DM; step("R3 only charge faults enabled");
    // R4: blocks, also over force and body diode
    clear_in(); bd = 1; step("R4 block dsg");
    clear_in(); bc = 1; step("R4 block chg");
    clear_in(); bc = 1; fc = 1; al = 1; step("R4 block beats force");
    clear_in(); flt[0] = 1; bd = 1; ser = 1; bde = 1; cur = 12'sd500;
    step("R4 block beats body diode");
    // R5: force
    clear_in(); flt = '1; fd = 1; fc = 1; al = 1; step("R5 force permitted");
    clear_in(); flt = '1; fd = 1; fc = 1; al = 0; step("R5 force not permitted");
    // R6: discharge turned on for charging current
    clear_in(); flt[0] = 1; ser = 1; bde = 1; cur = 12'sd101; step("R6 charge above thr");
    step("R6 held");
    clear_in(); flt[9] = 1; ser = 1; bde = 1; cur = 12'sd101; step("R6 both inhibited");
    // R7: charge turned on for discharging current
    clear_in(); flt[1] = 1; ser = 1; bde = 1; cur = -12'sd101; step("R7 discharge above thr");
    clear_in(); flt[1] = 1; ser = 1; bde = 1; cur = 12'h800; step("R7 most negative");
    // R8: no body diode action
    clear_in(); flt[0] = 1; ser = 1; bde = 1; cur = 12'sd100; step("R8 equal thr");
    clear_in(); flt[0] = 1; ser = 0; bde = 1; cur = 12'sd500; step("R8 parallel");
    clear_in(); flt[0] = 1; ser = 1; bde = 0; cur = 12'sd500; step("R8 disabled");
    clear_in(); flt[1] = 1; ser = 1; bde = 1; cur = 12'sd500; step("R8 wrong direction");
    // R9: detector enable with charge off only
    clear_in(); flt[1] = 1; step("R9 chg off dsg on");

    // R10: strobe length
    clear_in(); step("R10 chg on");
    flt[1] = 1; step("R10 chg falls");
    chk("R10 strobe rises", pull, 1);
    len = 0;
    while (pull && len < 1000) begin len++; @(negedge clk); end
    chk("R10 strobe length", len, PULL);

    // R11: abort on turn-on
    clear_in(); step("R11 chg on");
    flt[1] = 1; step("R11 chg falls");
    repeat (3) @(negedge clk);
    chk("R11 strobe mid window", pull, 1);
    clear_in(); step("R11 chg back on");
    chk("R11 strobe aborted", pull, 0);
    len = 0;
    for (int k = 0; k < PULL + 2; k++) begin
      if (pull) len++;
      @(negedge clk);
    end
    chk("R11 strobe stays low", len, 0);

    // R12: asynchronous reset during strobe
    flt[1] = 1; step("R12 chg falls");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R12 async clear", {chg_on, dsg_on, ocd_en, pull}, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    clear_in();
    repeat (4) @(negedge clk);
    step("R12 running again");
    @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule